// File: doc/BRIEF.md
# SCSI Initiator Register Command Front End

This block is the byte-wide register face of a simple SCSI initiator controller. A host reaches sixteen byte registers on a four-byte address stride. Each index has two registers behind it. Reads return a read-side bank that holds status, the interrupt cause, the sequence step, the live transfer count and the chip identification. Writes land in a write-side bank that holds the programmed transfer count, the selection target, the configuration values and the last command byte.

A byte written to the command register is decoded at once into a controller action. Bit 7 of the command byte asks for the live transfer count to be reloaded from its programmed value. The block keeps a level interrupt line towards the host. Reading the interrupt-cause register acknowledges that interrupt. Commands that need a bus sequence leave through a one-cycle start hook, which carries a kind code and the selected target. When the sequencer finishes, it posts its results back through a report port.

Top module: `scsi_regfront`

## Requirements
- R1: The register index is bus address bits [5:2], and higher address bits are ignored. A read returns the read-side register at that index and a write stores into the write-side register at that index. For example, writing 0x05 to index 4 (selection target) leaves a read of index 4 (status) at 0x00.
- R2: After a synchronous reset every read-side register is 0x00, except index 0xE, which reads 0x04 (chip identification). The interrupt line is low.
- R3: A command byte with bit 7 set copies the write-side values of indices 0 and 1 (transfer count low and mid) into the read-side registers at the same indices. With bit 7 clear, those read-side registers keep their values.
- R4: Command code 0x01 (flush) sets the interrupt-cause register (index 5) to 0x08 and the sequence-step register (index 6) to 0x00.
- R5: Command code 0x02 (chip reset) puts both banks back in their reset state, with 0x04 at read index 0xE, and deasserts the interrupt line. The write-side configuration is cleared too, so it no longer masks a later bus reset.
- R6: Command code 0x03 (bus reset) sets the interrupt-cause register to 0x80. The interrupt line rises on the next clock only if bit 6 of write-side index 8 (configuration 1) is clear.
- R7: A read of index 5 returns the pre-read value, clears status bits 7, 6 and 5 (interrupt, gross error, parity error) and drops the interrupt line. A read of any other index leaves the interrupt line as it is.
- R8: Command code 0x12 (message accepted) sets the interrupt-cause register to 0x20 (disconnect) and the sequence step to 0x00.
- R9: Command codes 0x11, 0x42 and 0x43 give a one-cycle pulse on seq_go_o on the clock after the write. The pulse carries kind 0, 1 and 2 respectively, and seq_target_o equals bits [2:0] of write-side index 4. Codes 0x44, 0x1A and 0x00 give no pulse.
- R10: A write to index 0xB is stored in the read bank ANDed with 0x15. Writes to indices 8, 9, 0xA and 0xC to 0xF are mirrored unchanged into the read bank.
- R11: A write to index 2 (FIFO) clears status bit 4 (count zero) and leaves the other status bits unchanged.
- R12: Any command code other than those listed above (for example 0x55 or 0x1A) changes nothing except the read-side copy of the command register at index 3, which reads back the last command byte.
- R13: A sequencer report (evt_valid) loads status, interrupt cause and sequence step, and raises the interrupt line. When a host access arrives in the same cycle, its effect is applied after the report: the read-clear of status bits applies, and the interrupt stays raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; has a side effect only at index 5 |
| rd_data | output | 8 | Read-side register at the addressed index (combinational) |
| evt_valid | input | 1 | Sequencer report strobe |
| evt_status | input | 8 | Status value posted by the sequencer |
| evt_intr | input | 8 | Interrupt cause posted by the sequencer |
| evt_step | input | 8 | Sequence step posted by the sequencer |
| irq_o | output | 1 | Level interrupt to the host |
| seq_go_o | output | 1 | One-cycle start pulse for the transfer sequencer |
| seq_kind_o | output | 2 | 0 command-complete, 1 select with ATN, 2 select with ATN and stop |
| seq_target_o | output | 3 | Target ID for the started sequence |

## Verification
A table of register accesses exercises the command decoder with every listed code, with the DMA reload bit both set and clear, and with codes the decoder does not know. This separates a correct reload from a stale one, and a real action from a silent no-op. Bus reset is issued with the configuration mask set, with it clear, and again after a chip reset. This shows whether the mask is read from the write bank and whether a chip reset clears it. Directed sequences post sequencer reports, alone and in the same cycle as an interrupt-register read. They check the status bits that the read and the FIFO write are meant to clear and the ones they must keep. Start-hook pulses are checked for kind, target and width.

// File: rtl/scsi_regfront_pkg.sv
// Shared constants and types for the SCSI register front end.
// Assumes a fixed map of sixteen byte registers; the index positions
// below are decoded by software and by the sequencer, so they are fixed.
package scsi_regfront_pkg;

    localparam int REG_CNT = 16;
    localparam int IDX_W   = 4;

    typedef logic [IDX_W-1:0] reg_idx_t;

    // register indices (read side / write side share an index)
    localparam reg_idx_t IX_CNT_LO  = 4'h0;
    localparam reg_idx_t IX_CNT_MID = 4'h1;
    localparam reg_idx_t IX_FIFO    = 4'h2;
    localparam reg_idx_t IX_CMD     = 4'h3;
    localparam reg_idx_t IX_STAT    = 4'h4;  // read: status, write: target
    localparam reg_idx_t IX_INTR    = 4'h5;
    localparam reg_idx_t IX_STEP    = 4'h6;
    localparam reg_idx_t IX_CFG1    = 4'h8;
    localparam reg_idx_t IX_CFG2    = 4'hB;
    localparam reg_idx_t IX_CNT_HI  = 4'hE;

    // status bits
    localparam int ST_CZERO = 4;
    localparam logic [7:0] ST_ACK_CLR = 8'hE0; // interrupt, gross, parity

    // interrupt-cause values
    localparam logic [7:0] IC_BUSRST = 8'h80;
    localparam logic [7:0] IC_DISC   = 8'h20;
    localparam logic [7:0] IC_FDONE  = 8'h08;

    // configuration-1 bit that hides the bus-reset interrupt
    localparam int CFG1_QUIET = 6;

    // command byte
    localparam int CMD_DMA_BIT = 7;
    localparam logic [6:0] OP_NOP     = 7'h00;
    localparam logic [6:0] OP_FLUSH   = 7'h01;
    localparam logic [6:0] OP_CHIPRST = 7'h02;
    localparam logic [6:0] OP_BUSRST  = 7'h03;
    localparam logic [6:0] OP_CMPLT   = 7'h11;
    localparam logic [6:0] OP_MSGOK   = 7'h12;
    localparam logic [6:0] OP_ATN     = 7'h1A;
    localparam logic [6:0] OP_SEL     = 7'h42;
    localparam logic [6:0] OP_SELSTOP = 7'h43;
    localparam logic [6:0] OP_ENSEL   = 7'h44;

    typedef enum logic [1:0] {
        SQ_CMPLT   = 2'd0,
        SQ_SEL     = 2'd1,
        SQ_SELSTOP = 2'd2
    } seq_kind_e;

    typedef struct packed {
        logic      flush;
        logic      chip_rst;
        logic      bus_rst;
        logic      msg_ok;
        logic      start;
        seq_kind_e kind;
        logic      reload;
    } cmd_act_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
// Command decoder: turns a command byte into a set of action strobes.
// Assumes cmd_valid is high only for a write to the command register.
// Purely combinational; codes without an action yield all-zero strobes.
module scsi_cmd_decode
    import scsi_regfront_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output cmd_act_t   act
);

    // map the low seven bits to one action, bit 7 to the count reload
    always_comb begin
        act        = '0;
        act.kind   = SQ_CMPLT;
        if (cmd_valid) begin
            act.reload = cmd_byte[CMD_DMA_BIT];
            case (cmd_byte[6:0])
                OP_FLUSH:   act.flush    = 1'b1;
                OP_CHIPRST: act.chip_rst = 1'b1;
                OP_BUSRST:  act.bus_rst  = 1'b1;
                OP_MSGOK:   act.msg_ok   = 1'b1;
                OP_CMPLT: begin
                    act.start = 1'b1;
                    act.kind  = SQ_CMPLT;
                end
                OP_SEL: begin
                    act.start = 1'b1;
                    act.kind  = SQ_SEL;
                end
                OP_SELSTOP: begin
                    act.start = 1'b1;
                    act.kind  = SQ_SELSTOP;
                end
                default: ; // no-op, attention, enable-selection, unknown
            endcase
        end
    end

endmodule

// File: rtl/scsi_irq_ctl.sv
// Level interrupt holder for the host line.
// Assumes synchronous active-low reset. Priority: clear, then raise,
// then lower, so a new cause is never lost to a same-cycle acknowledge.
module scsi_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic raise,
    input  logic lower,
    output logic irq
);

    // hold the line until acknowledged or the chip is reset
    always_ff @(posedge clk) begin
        if (!rst_n || clear) irq <= 1'b0;
        else if (raise)      irq <= 1'b1;
        else if (lower)      irq <= 1'b0;
    end

endmodule

// File: rtl/scsi_regfront.sv
// Register front end of a SCSI initiator: split read/write banks,
// command decode, interrupt line and a start hook for the sequencer.
// Assumes at most one host access per cycle and ADDR_W >= 6; address
// bits [1:0] and above bit 5 are ignored.
module scsi_regfront
    import scsi_regfront_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter logic [7:0] CHIP_ID   = 8'h04,
    parameter logic [7:0] CFG2_KEEP = 8'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    output logic [7:0]        rd_data,
    input  logic              evt_valid,
    input  logic [7:0]        evt_status,
    input  logic [7:0]        evt_intr,
    input  logic [7:0]        evt_step,
    output logic              irq_o,
    output logic              seq_go_o,
    output logic [1:0]        seq_kind_o,
    output logic [2:0]        seq_target_o
);

    localparam int IDX_LSB = 2;
    localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

    reg_idx_t   idx;
    logic [7:0] rbank [REG_CNT];
    logic [7:0] wbank [REG_CNT];
    logic [7:0] rnext [REG_CNT];
    logic [7:0] wnext [REG_CNT];
    cmd_act_t   act;
    logic       rd_ack;
    logic       unused_addr;

    assign idx    = bus_addr[IDX_MSB:IDX_LSB];
    assign rd_ack = rd_en && (idx == IX_INTR);

    // fold the ignored address bits so they are visibly consumed
    generate
        if (ADDR_W > IDX_MSB + 1) begin : g_hi
            assign unused_addr = ^{bus_addr[ADDR_W-1:IDX_MSB+1], bus_addr[IDX_LSB-1:0]};
        end else begin : g_lo
            assign unused_addr = ^bus_addr[IDX_LSB-1:0];
        end
    endgenerate

    scsi_cmd_decode u_dec (
        .cmd_valid (wr_en && (idx == IX_CMD)),
        .cmd_byte  (wr_data),
        .act       (act)
    );

    scsi_irq_ctl u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (act.chip_rst),
        .raise (evt_valid || (act.bus_rst && !wbank[IX_CFG1][CFG1_QUIET])),
        .lower (rd_ack),
        .irq   (irq_o)
    );

    // next bank state: sequencer report first, then the host access
    always_comb begin
        rnext = rbank;
        wnext = wbank;
        if (evt_valid) begin
            rnext[IX_STAT] = evt_status;
            rnext[IX_INTR] = evt_intr;
            rnext[IX_STEP] = evt_step;
        end
        if (rd_ack) rnext[IX_STAT] = rnext[IX_STAT] & ~ST_ACK_CLR;
        if (wr_en) begin
            wnext[idx] = wr_data;
            if (idx == IX_FIFO) rnext[IX_STAT][ST_CZERO] = 1'b0;
            if (idx == IX_CFG2)
                rnext[idx] = wr_data & CFG2_KEEP;
            else if (idx >= IX_CFG1)
                rnext[idx] = wr_data;
            if (idx == IX_CMD) begin
                rnext[IX_CMD] = wr_data;
                if (act.reload) begin
                    rnext[IX_CNT_LO]  = wbank[IX_CNT_LO];
                    rnext[IX_CNT_MID] = wbank[IX_CNT_MID];
                end
                if (act.flush) begin
                    rnext[IX_INTR] = IC_FDONE;
                    rnext[IX_STEP] = 8'h00;
                end
                if (act.bus_rst) rnext[IX_INTR] = IC_BUSRST;
                if (act.msg_ok) begin
                    rnext[IX_INTR] = IC_DISC;
                    rnext[IX_STEP] = 8'h00;
                end
            end
        end
    end

    // bank registers; reset and chip-reset command share one path
    always_ff @(posedge clk) begin
        if (!rst_n || act.chip_rst) begin
            for (int i = 0; i < REG_CNT; i++) begin
                rbank[i] <= (reg_idx_t'(i) == IX_CNT_HI) ? CHIP_ID : 8'h00;
                wbank[i] <= 8'h00;
            end
        end else begin
            rbank <= rnext;
            wbank <= wnext;
        end
    end

    // start hook, registered so it is a clean one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_go_o     <= 1'b0;
            seq_kind_o   <= 2'd0;
            seq_target_o <= 3'd0;
        end else begin
            seq_go_o     <= act.start;
            seq_kind_o   <= act.kind;
            seq_target_o <= wbank[IX_STAT][2:0];
        end
    end

    assign rd_data = rbank[idx];

endmodule

// File: rtl/scsi_regfront_chk.sv
// Property checker for scsi_regfront, attached by bind below.
// Assumes the same index decode as the design (address bits [5:2]).
module scsi_regfront_chk
    import scsi_regfront_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              rd_en,
    input logic              evt_valid,
    input logic              irq_o,
    input logic              seq_go_o,
    input logic [7:0]        cfg2_q,
    input logic [7:0]        id_q,
    input logic [7:0]        stat_q,
    input logic [7:0]        intr_q,
    input logic [7:0]        step_q
);

    reg_idx_t   c_idx;
    logic       c_cmd;
    logic [6:0] c_op;

    assign c_idx = bus_addr[5:2];
    assign c_cmd = wr_en && (c_idx == IX_CMD);
    assign c_op  = wr_data[6:0];

    AST_CFG2_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && c_idx == IX_CFG2) |=> (cfg2_q == ($past(wr_data) & 8'h15))); // R10

    AST_CHIP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && c_op == OP_CHIPRST) |=> (id_q == 8'h04 && stat_q == 8'h00 && !irq_o)); // R5

    AST_BUSRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && c_op == OP_BUSRST) |=> (intr_q == 8'h80)); // R6

    AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && c_op == OP_FLUSH) |=> (intr_q == 8'h08 && step_q == 8'h00)); // R4

    AST_MSG_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && c_op == OP_MSGOK) |=> (intr_q == 8'h20 && step_q == 8'h00)); // R8

    AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && c_idx == IX_INTR && !evt_valid && !c_cmd) |=> !irq_o); // R7

    AST_REPORT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !(c_cmd && c_op == OP_CHIPRST)) |=> irq_o); // R13

    AST_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_go_o |-> $past(c_cmd && (c_op == OP_CMPLT || c_op == OP_SEL || c_op == OP_SELSTOP))); // R9

endmodule

bind scsi_regfront scsi_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .evt_valid (evt_valid),
    .irq_o     (irq_o),
    .seq_go_o  (seq_go_o),
    .cfg2_q    (rbank[scsi_regfront_pkg::IX_CFG2]),
    .id_q      (rbank[scsi_regfront_pkg::IX_CNT_HI]),
    .stat_q    (rbank[scsi_regfront_pkg::IX_STAT]),
    .intr_q    (rbank[scsi_regfront_pkg::IX_INTR]),
    .step_q    (rbank[scsi_regfront_pkg::IX_STEP])
);

// File: tb/scsi_regfront_test.sv
// Self-checking bench: a vector table of register accesses, then
// directed sequences for reports, acknowledge races and the start hook.
module scsi_regfront_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       evt_valid = 1'b0;
    logic [7:0] evt_status = '0;
    logic [7:0] evt_intr = '0;
    logic [7:0] evt_step = '0;
    logic       irq_o;
    logic       seq_go_o;
    logic [1:0] seq_kind_o;
    logic [2:0] seq_target_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    scsi_regfront uut (
        .clk, .rst_n, .bus_addr, .wr_en, .wr_data, .rd_en, .rd_data,
        .evt_valid, .evt_status, .evt_intr, .evt_step,
        .irq_o, .seq_go_o, .seq_kind_o, .seq_target_o
    );

    // op(1) addr(6) data-or-expected(8) irq-after(1) requirement(4)
    localparam int NV = 43;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 6'h38, 8'h04, 1'b0, 4'd2},   // R2 chip id
        {1'b1, 6'h10, 8'h00, 1'b0, 4'd2},   // R2 status clear
        {1'b0, 6'h10, 8'h05, 1'b0, 4'd1},   // R1 write target
        {1'b1, 6'h10, 8'h00, 1'b0, 4'd1},   // R1 read side differs
        {1'b0, 6'h00, 8'h34, 1'b0, 4'd3},   // R3 program count low
        {1'b0, 6'h04, 8'h12, 1'b0, 4'd3},   // R3 program count mid
        {1'b1, 6'h00, 8'h00, 1'b0, 4'd1},   // R1 live count not yet loaded
        {1'b0, 6'h0C, 8'h00, 1'b0, 4'd3},   // R3 no-op without reload bit
        {1'b1, 6'h00, 8'h00, 1'b0, 4'd3},   // R3
        {1'b0, 6'h0C, 8'h80, 1'b0, 4'd3},   // R3 no-op with reload bit
        {1'b1, 6'h00, 8'h34, 1'b0, 4'd3},   // R3
        {1'b1, 6'h04, 8'h12, 1'b0, 4'd3},   // R3
        {1'b1, 6'h0C, 8'h80, 1'b0, 4'd12},  // R12 command read back
        {1'b0, 6'h2C, 8'hFF, 1'b0, 4'd10},  // R10 config 2
        {1'b1, 6'h2C, 8'h15, 1'b0, 4'd10},  // R10 masked
        {1'b0, 6'h24, 8'hA5, 1'b0, 4'd10},  // R10 index 9
        {1'b1, 6'h24, 8'hA5, 1'b0, 4'd10},  // R10 mirrored
        {1'b0, 6'h20, 8'h40, 1'b0, 4'd6},   // R6 quiet bit set
        {1'b0, 6'h0C, 8'h03, 1'b0, 4'd6},   // R6 masked bus reset
        {1'b1, 6'h14, 8'h80, 1'b0, 4'd6},   // R6 cause recorded
        {1'b0, 6'h20, 8'h00, 1'b0, 4'd6},   // R6 quiet bit clear
        {1'b0, 6'h0C, 8'h03, 1'b1, 4'd6},   // R6 line rises
        {1'b1, 6'h10, 8'h00, 1'b1, 4'd7},   // R7 status read keeps line
        {1'b1, 6'h14, 8'h80, 1'b0, 4'd7},   // R7 acknowledge
        {1'b0, 6'h0C, 8'h01, 1'b0, 4'd4},   // R4 flush
        {1'b1, 6'h14, 8'h08, 1'b0, 4'd4},   // R4
        {1'b1, 6'h18, 8'h00, 1'b0, 4'd4},   // R4
        {1'b0, 6'h0C, 8'h12, 1'b0, 4'd8},   // R8 message accepted
        {1'b1, 6'h14, 8'h20, 1'b0, 4'd8},   // R8
        {1'b1, 6'h18, 8'h00, 1'b0, 4'd8},   // R8
        {1'b0, 6'h0C, 8'h55, 1'b0, 4'd12},  // R12 unknown code
        {1'b1, 6'h14, 8'h20, 1'b0, 4'd12},  // R12 cause untouched
        {1'b1, 6'h0C, 8'h55, 1'b0, 4'd12},  // R12 recorded
        {1'b0, 6'h0C, 8'h1A, 1'b0, 4'd12},  // R12 attention code
        {1'b1, 6'h14, 8'h20, 1'b0, 4'd12},  // R12
        {1'b0, 6'h20, 8'h40, 1'b0, 4'd5},   // R5 quiet bit before reset
        {1'b0, 6'h0C, 8'h02, 1'b0, 4'd5},   // R5 chip reset
        {1'b1, 6'h38, 8'h04, 1'b0, 4'd5},   // R5 chip id reloaded
        {1'b1, 6'h2C, 8'h00, 1'b0, 4'd5},   // R5
        {1'b1, 6'h00, 8'h00, 1'b0, 4'd5},   // R5
        {1'b1, 6'h0C, 8'h00, 1'b0, 4'd5},   // R5
        {1'b0, 6'h0C, 8'h03, 1'b1, 4'd5},   // R5 quiet bit cleared
        {1'b1, 6'h14, 8'h80, 1'b0, 4'd7}    // R7
    };

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; rd_en = 1'b1;
        #1 check(rd_data, exp, req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cmd_go(input logic [7:0] c, input logic go, input logic [1:0] kind,
                          input logic [2:0] tgt);
        wr(6'h0C, c);
        check({7'd0, seq_go_o}, {7'd0, go}, "R9 pulse");
        if (go) begin
            check({6'd0, seq_kind_o}, {6'd0, kind}, "R9 kind");
            check({5'd0, seq_target_o}, {5'd0, tgt}, "R9 target");
        end
        @(negedge clk);
        check({7'd0, seq_go_o}, 8'd0, "R9 one cycle");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({7'd0, irq_o}, 8'd0, "R2 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            string       tag;
            v   = VEC[i];
            tag = $sformatf("R%0d vec %0d", v[3:0], i);
            if (v[19]) rd(v[18:13], v[12:5], tag);
            else       wr(v[18:13], v[12:5]);
            check({7'd0, irq_o}, {7'd0, v[4]}, {tag, " irq"});
        end

        // R13 sequencer report, then R11 FIFO write and R7 acknowledge
        evt_status = 8'hF0; evt_intr = 8'h10; evt_step = 8'h04; evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        check({7'd0, irq_o}, 8'd1, "R13 irq");
        rd(6'h10, 8'hF0, "R13 status");
        rd(6'h18, 8'h04, "R13 step");
        wr(6'h08, 8'h3C);
        rd(6'h10, 8'hE0, "R11 count-zero cleared");
        wr(6'h0C, 8'h01);
        rd(6'h18, 8'h00, "R4 step after report");
        rd(6'h14, 8'h08, "R7 pre-read value");
        rd(6'h10, 8'h00, "R7 status bits cleared");
        check({7'd0, irq_o}, 8'd0, "R7 irq low");

        // R13 report and acknowledge in the same cycle
        evt_status = 8'hF0; evt_intr = 8'h10; evt_step = 8'h03; evt_valid = 1'b1;
        rd(6'h14, 8'h08, "R13 race read value");
        evt_valid = 1'b0;
        check({7'd0, irq_o}, 8'd1, "R13 race irq stays");
        rd(6'h10, 8'h10, "R13 race status");
        rd(6'h14, 8'h10, "R13 race cause");
        check({7'd0, irq_o}, 8'd0, "R7 final ack");

        // R9 start hook
        wr(6'h10, 8'h0E);
        cmd_go(8'h43, 1'b1, 2'd2, 3'd6);
        cmd_go(8'hC2, 1'b1, 2'd1, 3'd6);
        cmd_go(8'h11, 1'b1, 2'd0, 3'd6);
        cmd_go(8'h44, 1'b0, 2'd0, 3'd0);
        cmd_go(8'h1A, 1'b0, 2'd0, 3'd0);
        cmd_go(8'h00, 1'b0, 2'd0, 3'd0);

        // R2 reset pulse mid-run
        wr(6'h2C, 8'hFF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(6'h38, 8'h04, "R2 id after reset");
        rd(6'h2C, 8'h00, "R2 config after reset");
        check({7'd0, irq_o}, 8'd0, "R2 irq after reset");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule